// File: doc/BRIEF.md
# Power-Chain Enable Sequencer

This block drives the power switches of an SoC's internal supply domains. When reset is released, and again after every wake from deep sleep, it turns the domains on one step at a time so the inrush current stays low. Each step switches on one domain, then waits for that domain's ready acknowledge or for a programmable timeout, and only then moves to the next domain. A chain-complete flag reports when every domain is up. When the CPU requests a deep sleep mode (power-down or power-save), the block switches the domains off one per cycle in reverse order. SRAM banks marked for retention stay powered. A wake event that arrives part-way through a shutdown stops it and restarts the enable chain from the first domain that is off.

The block also holds two radio-side controls. The first is a self-clearing radio reset bit that produces a single-cycle reset pulse. The second is a radio sleep bit, which reaches the radio only while the radio reports that it is in its off state.

The domain indices are fixed by the enable order, with `NB` SRAM banks (default 4):

| Index | Domain |
|---|---|
| 0 | bandgap reference and main regulator |
| 1 | digital regulator and low-leakage regulator |
| 2 .. 1+NB | SRAM banks 0 .. NB-1 |
| NB+2 | non-volatile memory |
| NB+3 | radio signal processor |

The sequencer has five states:

| State | Meaning |
|---|---|
| ST_UP_EN | switch on the current domain |
| ST_UP_WAIT | wait for ready or timeout |
| ST_DONE | chain complete |
| ST_DOWN | switch off one domain per cycle |
| ST_ASLEEP | all non-retained domains off |

The transitions are:

- Reset releases into ST_UP_EN at index 0.
- ST_UP_EN always moves to ST_UP_WAIT.
- ST_UP_WAIT moves to ST_UP_EN at the next index on ready or timeout, or to ST_DONE after the last index.
- ST_DONE moves to ST_DOWN at the last index on a deep-sleep request.
- ST_DOWN steps downward and moves to ST_ASLEEP after index 0. On wake it moves to ST_UP_EN at the lowest unpowered index.
- ST_ASLEEP moves to ST_UP_EN at the lowest unpowered index on wake.

Top module: `pwr_chain_seq`

## Requirements
- R1: After reset is released, domains switch on in strictly ascending index order. `dom_en` always has the form 2^k-1 while the chain runs from reset.
- R2: At most one bit of `dom_en` changes per clock. Each step takes one enable cycle followed by its wait cycles before the next domain is switched on.
- R3: A wait ends in the cycle where the current domain's `dom_rdy` bit is high, or after `tmo_lim`+1 wait cycles. With a ready delay of d cycles, each of the 8 default domains takes min(d, tmo_lim)+2 cycles.
- R4: A wait that ends by timeout without ready sets `tmo_err`. The flag stays set through later sleeps and wakes, and only reset clears it.
- R5: `chain_ok` rises in the cycle after the last domain's wait ends. From reset release this is 8*(min(d, tmo_lim)+2) clock edges with default parameters.
- R6: A `sleep_req` in the complete state with `sleep_mode` equal to 3'b010 (power-down) or 3'b011 (power-save) drops `chain_ok` on the next cycle. Domains are then switched off one per cycle, highest index first. Any other mode value is ignored.
- R7: During shutdown, the bank whose `ret_keep` bit b is set (domain index 2+b) stays on.
- R8: A wake from sleep restarts the enable chain from the lowest unpowered domain and ends with all domains on and `chain_ok` high.
- R9: A wake during shutdown aborts it. In the cycle where wake is seen, the pending off step is not taken, so `dom_en` keeps the value it had.
- R10: A one-cycle `rrst_wr` strobe produces `radio_rst` high for exactly one cycle, on the cycle after the strobe. `radio_rst` is never high on two consecutive cycles.
- R11: `radio_slp` follows the written sleep bit only while `radio_is_off` is high, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset, power-on |
| sleep_req | input | 1 | CPU sleep request strobe |
| sleep_mode | input | 3 | requested sleep mode (3'b010 power-down, 3'b011 power-save) |
| wake | input | 1 | wake event |
| dom_rdy | input | NB+4 | per-domain ready acknowledge |
| ret_keep | input | NB | per-bank retention select |
| tmo_lim | input | TW | ready timeout limit in cycles |
| rrst_wr | input | 1 | write of 1 to the radio reset bit |
| radio_slp_wr | input | 1 | write strobe for the radio sleep bit |
| radio_slp_val | input | 1 | value written to the radio sleep bit |
| radio_is_off | input | 1 | radio reports its off state |
| dom_en | output | NB+4 | per-domain power switch enable |
| chain_ok | output | 1 | chain complete |
| tmo_err | output | 1 | sticky timeout error |
| radio_rst | output | 1 | single-cycle radio reset |
| radio_slp | output | 1 | gated radio sleep request |

## Verification
Two events can fall in the same cycle: a wake event, and a pending off step of an ongoing shutdown. The bench provokes this with a power-save request. It lets two domains switch off, then holds wake high across the edge on which the third domain would have switched off. The check passes only if `dom_en` still shows exactly two domains removed, which proves that the wake took priority over the off step. The check also requires that the restarted chain then brings every domain back and raises `chain_ok` again.

// File: rtl/pwr_chain_pkg.sv
package pwr_chain_pkg;

    typedef enum logic [2:0] {
        ST_UP_EN   = 3'd0,
        ST_UP_WAIT = 3'd1,
        ST_DONE    = 3'd2,
        ST_DOWN    = 3'd3,
        ST_ASLEEP  = 3'd4
    } seq_state_e;

    localparam logic [2:0] MODE_PWR_DOWN = 3'b010;
    localparam logic [2:0] MODE_PWR_SAVE = 3'b011;

    // Index of the first SRAM bank in the domain vector
    localparam int BANK_BASE = 2;

    function automatic logic is_deep_mode(input logic [2:0] mode);
        return (mode == MODE_PWR_DOWN) || (mode == MODE_PWR_SAVE);
    endfunction

endpackage

// File: rtl/pwr_keep_mask.sv
module pwr_keep_mask #(
    parameter int NB   = 4,
    parameter int NDOM = NB + 4
) (
    input  logic [NB-1:0]   ret_keep,
    output logic [NDOM-1:0] keep_mask
);
    import pwr_chain_pkg::*;

    for (genvar d = 0; d < NDOM; d++) begin : g_dom
        if (d >= BANK_BASE && d < BANK_BASE + NB) begin : g_bank
            assign keep_mask[d] = ret_keep[d-BANK_BASE];
        end else begin : g_plain
            assign keep_mask[d] = 1'b0;
        end
    end

endmodule

// File: rtl/pwr_step_timer.sv
module pwr_step_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [TW-1:0] lim,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q != {TW{1'b1}}) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (cnt_q >= lim);

    // R3: the counter starts from zero on each new wait
    p_cnt_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm #(
    parameter int NB   = 4,
    parameter int TW   = 8,
    parameter int NDOM = NB + 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sleep_req,
    input  logic [2:0]      sleep_mode,
    input  logic            wake,
    input  logic [NDOM-1:0] dom_rdy,
    input  logic [NDOM-1:0] keep_mask,
    input  logic [TW-1:0]   tmo_lim,
    output logic [NDOM-1:0] dom_en,
    output logic            chain_ok,
    output logic            tmo_err
);
    import pwr_chain_pkg::*;

    localparam int IW = (NDOM > 1) ? $clog2(NDOM) : 1;
    localparam logic [IW-1:0] LAST = IW'(NDOM - 1);

    seq_state_e      state_q, state_d;
    logic [IW-1:0]   idx_q, idx_d;
    logic [NDOM-1:0] en_q, en_d;
    logic            ok_q, ok_d;
    logic            err_q, err_d;
    logic            tmo_hit;
    logic            deep_req;

    function automatic logic [IW-1:0] first_off(input logic [NDOM-1:0] en);
        logic [IW-1:0] r;
        r = LAST;
        for (int i = NDOM - 1; i >= 0; i--) begin
            if (!en[i]) r = IW'(i);
        end
        return r;
    endfunction

    pwr_step_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q == ST_UP_WAIT),
        .lim     (tmo_lim),
        .expired (tmo_hit)
    );

    assign deep_req = sleep_req && is_deep_mode(sleep_mode);

    // Next-state and register-update logic
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        en_d    = en_q;
        ok_d    = ok_q;
        err_d   = err_q;
        unique case (state_q)
            ST_UP_EN: begin
                en_d[idx_q] = 1'b1;
                state_d     = ST_UP_WAIT;
            end
            ST_UP_WAIT: begin
                if (dom_rdy[idx_q] || tmo_hit) begin
                    if (!dom_rdy[idx_q]) err_d = 1'b1;
                    if (idx_q == LAST) begin
                        ok_d    = 1'b1;
                        state_d = ST_DONE;
                    end else begin
                        idx_d   = idx_q + 1'b1;
                        state_d = ST_UP_EN;
                    end
                end
            end
            ST_DONE: begin
                if (deep_req) begin
                    ok_d    = 1'b0;
                    idx_d   = LAST;
                    state_d = ST_DOWN;
                end
            end
            ST_DOWN: begin
                if (wake) begin
                    idx_d   = first_off(en_q);
                    state_d = ST_UP_EN;
                end else begin
                    if (!keep_mask[idx_q]) en_d[idx_q] = 1'b0;
                    if (idx_q == '0) state_d = ST_ASLEEP;
                    else             idx_d   = idx_q - 1'b1;
                end
            end
            ST_ASLEEP: begin
                if (wake) begin
                    idx_d   = first_off(en_q);
                    state_d = ST_UP_EN;
                end
            end
            default: state_d = ST_UP_EN;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_UP_EN;
            idx_q   <= '0;
            en_q    <= '0;
            ok_q    <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            en_q    <= en_d;
            ok_q    <= ok_d;
            err_q   <= err_d;
        end
    end

    // Outputs
    always_comb begin
        dom_en   = en_q;
        chain_ok = ok_q;
        tmo_err  = err_q;
    end

    // R2: one switch moves per clock at most
    p_one_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(en_q ^ $past(en_q)) <= 1);

    // R4: the error flag never clears outside reset
    p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

    // R5: complete only with every domain on
    p_ok_all_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ok_q) |-> (&en_q));

    // R6: a deep request in the complete state drops the flag next cycle
    p_ok_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && deep_req) |=> !ok_q);

    // R7: a retained bank survives its shutdown step
    p_keep_retained_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DOWN && !wake && keep_mask[idx_q] && en_q[idx_q])
        |=> en_q[$past(idx_q)]);

    // R9: wake during shutdown freezes the switch vector for that cycle
    p_wake_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DOWN && wake) |=> $stable(en_q));

endmodule

// File: rtl/pwr_radio_ctl.sv
module pwr_radio_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic rrst_wr,
    input  logic radio_slp_wr,
    input  logic radio_slp_val,
    input  logic radio_is_off,
    output logic radio_rst,
    output logic radio_slp
);
    logic rst_bit_q;
    logic slp_bit_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_bit_q <= 1'b0;
            slp_bit_q <= 1'b0;
        end else begin
            rst_bit_q <= rrst_wr && !rst_bit_q;
            if (radio_slp_wr) slp_bit_q <= radio_slp_val;
        end
    end

    always_comb begin
        radio_rst = rst_bit_q;
        radio_slp = slp_bit_q && radio_is_off;
    end

    // R10: the reset pulse never lasts two cycles
    p_rst_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        radio_rst |=> !radio_rst);

    // R11: no sleep request reaches a radio that is not off
    p_slp_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        radio_slp |-> radio_is_off);

endmodule

// File: rtl/pwr_chain_seq.sv
module pwr_chain_seq #(
    parameter int NB   = 4,
    parameter int TW   = 8,
    parameter int NDOM = NB + 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sleep_req,
    input  logic [2:0]      sleep_mode,
    input  logic            wake,
    input  logic [NDOM-1:0] dom_rdy,
    input  logic [NB-1:0]   ret_keep,
    input  logic [TW-1:0]   tmo_lim,
    input  logic            rrst_wr,
    input  logic            radio_slp_wr,
    input  logic            radio_slp_val,
    input  logic            radio_is_off,
    output logic [NDOM-1:0] dom_en,
    output logic            chain_ok,
    output logic            tmo_err,
    output logic            radio_rst,
    output logic            radio_slp
);
    logic [NDOM-1:0] keep_mask;

    pwr_keep_mask #(.NB(NB), .NDOM(NDOM)) u_keep (
        .ret_keep  (ret_keep),
        .keep_mask (keep_mask)
    );

    pwr_seq_fsm #(.NB(NB), .TW(TW), .NDOM(NDOM)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_req  (sleep_req),
        .sleep_mode (sleep_mode),
        .wake       (wake),
        .dom_rdy    (dom_rdy),
        .keep_mask  (keep_mask),
        .tmo_lim    (tmo_lim),
        .dom_en     (dom_en),
        .chain_ok   (chain_ok),
        .tmo_err    (tmo_err)
    );

    pwr_radio_ctl u_radio (
        .clk           (clk),
        .rst_n         (rst_n),
        .rrst_wr       (rrst_wr),
        .radio_slp_wr  (radio_slp_wr),
        .radio_slp_val (radio_slp_val),
        .radio_is_off  (radio_is_off),
        .radio_rst     (radio_rst),
        .radio_slp     (radio_slp)
    );

endmodule

// File: tb/test_pwr_chain_seq.sv
module test_pwr_chain_seq;
    localparam int NB   = 4;
    localparam int TW   = 8;
    localparam int NDOM = NB + 4;
    localparam int NVEC = 8;

    // Each row: {tmo_lim, ready delay, expected error}
    localparam logic [16:0] VEC [NVEC] = '{
        {8'd3, 8'd0,   1'b0},
        {8'd3, 8'd2,   1'b0},
        {8'd3, 8'd3,   1'b0},
        {8'd3, 8'd4,   1'b1},
        {8'd0, 8'd0,   1'b0},
        {8'd0, 8'd2,   1'b1},
        {8'd6, 8'd1,   1'b0},
        {8'd2, 8'd200, 1'b1}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            sleep_req = 1'b0;
    logic [2:0]      sleep_mode = 3'b000;
    logic            wake = 1'b0;
    logic [NDOM-1:0] dom_rdy;
    logic [NB-1:0]   ret_keep = '0;
    logic [TW-1:0]   tmo_lim = 8'd3;
    logic            rrst_wr = 1'b0;
    logic            radio_slp_wr = 1'b0;
    logic            radio_slp_val = 1'b0;
    logic            radio_is_off = 1'b0;
    logic [NDOM-1:0] dom_en;
    logic            chain_ok;
    logic            tmo_err;
    logic            radio_rst;
    logic            radio_slp;

    logic [7:0] dly = 8'd0;
    logic [7:0] age [NDOM];
    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    pwr_chain_seq #(.NB(NB), .TW(TW)) i_pwr_chain_seq (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sleep_mode(sleep_mode),
        .wake(wake), .dom_rdy(dom_rdy), .ret_keep(ret_keep), .tmo_lim(tmo_lim),
        .rrst_wr(rrst_wr), .radio_slp_wr(radio_slp_wr), .radio_slp_val(radio_slp_val),
        .radio_is_off(radio_is_off), .dom_en(dom_en), .chain_ok(chain_ok),
        .tmo_err(tmo_err), .radio_rst(radio_rst), .radio_slp(radio_slp)
    );

    always #2 clk = ~clk;

    // Domain model: ready after dly cycles of being switched on
    always @(posedge clk) begin
        for (int i = 0; i < NDOM; i++) begin
            if (!dom_en[i])         age[i] <= 8'd0;
            else if (age[i] != 8'hFF) age[i] <= age[i] + 8'd1;
        end
    end
    always_comb begin
        for (int i = 0; i < NDOM; i++) dom_rdy[i] = dom_en[i] && (age[i] >= dly);
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    // Counts edges until chain_ok; reports whether any non-prefix vector appeared
    task automatic wait_ok(output int edges, output logic order_bad);
        edges = 0;
        order_bad = 1'b0;
        while (!chain_ok && edges < 5000) begin
            @(negedge clk);
            edges++;
            if ((dom_en & (dom_en + 1'b1)) != '0) order_bad = 1'b1;
        end
    endtask

    task automatic do_reset(input logic [7:0] lim, input logic [7:0] d);
        @(negedge clk);
        rst_n = 1'b0;
        tmo_lim = lim;
        dly = d;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        int   edges;
        logic obad;
        int   w;

        // Reset state
        @(negedge clk);
        check(dom_en == '0, "R1 reset dom_en", int'(dom_en), 0);
        check(!chain_ok && !tmo_err && !radio_rst, "R5 reset flags",
              int'({chain_ok, tmo_err, radio_rst}), 0);

        // Vector table: R1 order, R3 wait length, R4 error, R5 completion time
        for (int v = 0; v < NVEC; v++) begin
            do_reset(VEC[v][16:9], VEC[v][8:1]);
            wait_ok(edges, obad);
            w = (VEC[v][8:1] < VEC[v][16:9]) ? int'(VEC[v][8:1]) : int'(VEC[v][16:9]);
            check(!obad, "R1 ascending order", int'(obad), 0);
            check(edges == NDOM * (w + 2), "R3 R5 chain time", edges, NDOM * (w + 2));
            check(tmo_err == VEC[v][0], "R4 timeout error", int'(tmo_err), int'(VEC[v][0]));
        end

        // Directed tests with short ready delay
        do_reset(8'd3, 8'd1);
        wait_ok(edges, obad);
        check(!obad && edges == NDOM * 3, "R2 step per domain", edges, NDOM * 3);

        // R6: non-deep mode is ignored
        sleep_mode = 3'b000;
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        repeat (10) @(negedge clk);
        check(chain_ok && dom_en == '1, "R6 light mode ignored", int'(dom_en), 255);

        // R6/R7: power-down with banks 0 and 2 retained
        ret_keep = 4'b0101;
        sleep_mode = 3'b010;
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        check(!chain_ok, "R6 chain_ok drop", int'(chain_ok), 0);
        @(negedge clk);
        check(dom_en == 8'h7F, "R6 highest first", int'(dom_en), 8'h7F);
        repeat (10) @(negedge clk);
        check(dom_en == 8'h14, "R7 retained banks", int'(dom_en), 8'h14);

        // R8: wake from sleep
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
        wait_ok(edges, obad);
        check(chain_ok && dom_en == '1, "R8 wake restart", int'(dom_en), 255);

        // R9: wake collides with a pending off step
        ret_keep = '0;
        sleep_mode = 3'b011;
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(dom_en == 8'h3F, "R6 power-save steps", int'(dom_en), 8'h3F);
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
        check(dom_en == 8'h3F, "R9 wake abort", int'(dom_en), 8'h3F);
        wait_ok(edges, obad);
        check(chain_ok && dom_en == '1, "R8 after abort", int'(dom_en), 255);

        // R4: sticky across sleep and wake
        do_reset(8'd0, 8'd2);
        wait_ok(edges, obad);
        dly = 8'd0;
        sleep_mode = 3'b010;
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        repeat (12) @(negedge clk);
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
        wait_ok(edges, obad);
        check(tmo_err, "R4 sticky error", int'(tmo_err), 1);
        do_reset(8'd3, 8'd0);
        @(negedge clk);
        check(!tmo_err, "R4 reset clears", int'(tmo_err), 0);

        // R10: radio reset pulse
        rrst_wr = 1'b1;
        @(negedge clk);
        rrst_wr = 1'b0;
        check(radio_rst, "R10 pulse high", int'(radio_rst), 1);
        @(negedge clk);
        check(!radio_rst, "R10 pulse cleared", int'(radio_rst), 0);

        // R11: radio sleep gating
        radio_is_off = 1'b0;
        radio_slp_wr = 1'b1;
        radio_slp_val = 1'b1;
        @(negedge clk);
        radio_slp_wr = 1'b0;
        check(!radio_slp, "R11 blocked while on", int'(radio_slp), 0);
        radio_is_off = 1'b1;
        @(negedge clk);
        check(radio_slp, "R11 honoured when off", int'(radio_slp), 1);

        finish_run();
    end

endmodule